// File: doc/BRIEF.md
# Two-Channel DMA Register Bank

This block holds the software-visible control state of a two-channel scatter-gather DMA engine. Each channel has a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. Software reaches all of them through a 32-bit register bus that carries a valid, a write flag, a byte address and write data. The bank drives the run, soft-reset and interrupt-enable controls to the channel engines. It combines pending events with their enables into one interrupt line per channel. A write to the tail pointer of channel 0 produces a one-cycle start pulse for the transmit engine.

The engines report halted and idle conditions and interrupt events back to the bank as single-cycle set pulses. The completion counter and the delay timer are kept outside the block. Their live 8-bit values are inserted into the upper bits of the status word on every read. Some behaviour is fixed by the bank. The tail-pointer mode bit always reads as one. A soft reset remains pending until the control word is read once. Interrupt flags are cleared by writing one to them.

Top module: `dma_regbank`

## Requirements
- R1: Each channel occupies a window of 0x30 bytes. The channel is (addr / 0x30) mod 2, so 0x60 maps to channel 0 again. Within a window, 0x00 is control, 0x04 is status, 0x08 is the current descriptor and 0x10 is the tail descriptor. Any other offset reads as zero, and writes to it change nothing. Read data appears on `bus_rdata` in the cycle after the read and holds until the next read.
- R2: A control write stores the written word with bit 1 (tail-pointer mode) forced to 1, and it keeps bit 2 set if bit 2 was already set.
- R3: When a control write leaves bit 2 (soft reset) set, control becomes 0x00010006 and status becomes halted only, with all pending flags cleared. `ch_srst` shows bit 2. A control read returns the word with bit 2 cleared, and it also clears bit 2 in the register.
- R4: After `rst_n` is released, control is 0x00010000 (threshold 1 in bits 23:16), status holds only halted (bit 0), and both descriptor pointers are 0.
- R5: A control write with bit 0 (run) set clears halted and idle (status bit 1), provided no soft reset is pending and the write does not request one.
- R6: Status bits 14:12 are pending flags, set by the engine's `eng_pend` pulses (bit 12 completion, bit 13 delay timeout, bit 14 error). Writing 1 to a flag clears it. An event in the same cycle as the clear wins, and the flag stays set.
- R7: A status read returns {timer[7:0], count[7:0], 0, pending[2:0], ten zeros, idle, halted}, where timer and count are the channel's live inputs in the read cycle.
- R8: A tail write clears idle. On channel 0 it raises `tx_kick` for exactly the following cycle. A channel 1 tail write raises no kick.
- R9: `ch_irq` of a channel is high when any pending flag is set together with its enable in control bits 14:12.
- R10: An `eng_halt` or `eng_idle` pulse sets its flag even when a run write or tail write in the same cycle would clear it.
- R11: `ch_run` shows control bit 0 and `ch_ien` shows control bits 14:12 of each channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| eng_halt | input | 2 | Per-channel halted set pulse |
| eng_idle | input | 2 | Per-channel idle set pulse |
| eng_pend | input | 6 | Per-channel pending event pulses, 3 bits per channel |
| cnt_live | input | 16 | Live completion count, 8 bits per channel |
| tmr_live | input | 16 | Live delay-timer count, 8 bits per channel |
| ch_run | output | 2 | Run control per channel |
| ch_srst | output | 2 | Soft reset pending per channel |
| ch_ien | output | 6 | Interrupt enables, 3 bits per channel |
| ch_irq | output | 2 | Interrupt line per channel |
| tx_kick | output | 1 | Start pulse after a channel 0 tail write |

## Verification
Two kinds of collision are tested: a software write and an engine report that reach the same status bit in one cycle. The first is a write-one-to-clear of a pending flag together with the event that sets it. The second is a run write or tail write together with a halt or idle pulse. The bench produces both pairs in directed steps, and the random phase drives events during bus traffic. Each time, the next status read must show the engine's set.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int DW    = 32;
  localparam int FLD_W = 8;
  localparam int NPEND = 3;

  localparam int B_RUN   = 0;
  localparam int B_TPM   = 1;
  localparam int B_SRST  = 2;
  localparam int B_PEND  = 12;

  localparam logic [DW-1:0] CTRL_POR  = 32'h0001_0000;
  localparam logic [DW-1:0] CTRL_SRST = CTRL_POR | 32'h6;

  typedef enum logic [2:0] {RG_CTRL, RG_STAT, RG_CUR, RG_TAIL, RG_NONE} reg_sel_e;

  function automatic reg_sel_e word_to_sel(input logic [31:0] widx);
    case (widx)
      32'd0:   return RG_CTRL;
      32'd1:   return RG_STAT;
      32'd2:   return RG_CUR;
      32'd4:   return RG_TAIL;
      default: return RG_NONE;
    endcase
  endfunction

  function automatic logic [DW-1:0] ctrl_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] wr_v);
    return wr_v | (32'd1 << B_TPM) | (old_v & (32'd1 << B_SRST));
  endfunction

  function automatic logic [DW-1:0] stat_pack(input logic halted, input logic idle,
                                              input logic [NPEND-1:0] pend,
                                              input logic [FLD_W-1:0] cnt,
                                              input logic [FLD_W-1:0] tmr);
    return {tmr, cnt, 1'b0, pend, 10'b0, idle, halted};
  endfunction

  function automatic logic irq_calc(input logic [NPEND-1:0] pend,
                                    input logic [NPEND-1:0] ien);
    return |(pend & ien);
  endfunction
endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
  import dmarb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2,
  parameter int WIN    = 48,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CH_W-1:0]   chan,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:0] win_idx;
  logic [ADDR_W-1:0] offs;

  assign win_idx = addr / ADDR_W'(WIN);
  assign offs    = addr % ADDR_W'(WIN);
  assign chan    = CH_W'(win_idx % ADDR_W'(NCH));
  assign sel     = word_to_sel(32'(offs >> 2));
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
  import dmarb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_stat,
  input  logic             wr_cur,
  input  logic             wr_tail,
  input  logic             rd_ctrl,
  input  logic [DW-1:0]    wdata,
  input  logic             halt_set,
  input  logic             idle_set,
  input  logic [NPEND-1:0] pend_evt,
  input  logic [FLD_W-1:0] cnt_live,
  input  logic [FLD_W-1:0] tmr_live,
  output logic [DW-1:0]    ctrl_o,
  output logic [DW-1:0]    stat_o,
  output logic [DW-1:0]    cur_o,
  output logic [DW-1:0]    tail_o,
  output logic             irq_o
);
  logic [DW-1:0]    ctrl_q, cur_q, tail_q;
  logic             halted_q, idle_q;
  logic [NPEND-1:0] pend_q;

  logic [DW-1:0]    ctrl_wr_v;
  logic             ev_soft_rst, ev_run_start;

  assign ctrl_wr_v    = ctrl_merge(ctrl_q, wdata);
  assign ev_soft_rst  = wr_ctrl && ctrl_wr_v[B_SRST];
  assign ev_run_start = wr_ctrl && !ctrl_wr_v[B_SRST] && ctrl_wr_v[B_RUN];

  logic [DW-1:0]    ctrl_n;
  logic             halted_n, idle_n;
  logic [NPEND-1:0] pend_n;

  always_comb begin
    ctrl_n   = ctrl_q;
    halted_n = halted_q;
    idle_n   = idle_q;
    pend_n   = pend_q;
    if (ev_soft_rst) begin
      ctrl_n   = CTRL_SRST;
      halted_n = 1'b1;
      idle_n   = 1'b0;
      pend_n   = '0;
    end else if (wr_ctrl) begin
      ctrl_n = ctrl_wr_v;
    end
    if (ev_run_start) begin
      halted_n = 1'b0;
      idle_n   = 1'b0;
    end
    if (rd_ctrl) ctrl_n[B_SRST] = 1'b0;
    if (wr_stat) pend_n = pend_n & ~wdata[B_PEND +: NPEND];
    if (wr_tail) idle_n = 1'b0;
    // engine reports take priority over software clears
    pend_n   = pend_n | pend_evt;
    halted_n = halted_n | halt_set;
    idle_n   = idle_n | idle_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_POR;
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
      pend_q   <= '0;
      cur_q    <= '0;
      tail_q   <= '0;
    end else begin
      ctrl_q   <= ctrl_n;
      halted_q <= halted_n;
      idle_q   <= idle_n;
      pend_q   <= pend_n;
      if (wr_cur)  cur_q  <= wdata;
      if (wr_tail) tail_q <= wdata;
    end
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_pack(halted_q, idle_q, pend_q, cnt_live, tmr_live);
  assign cur_o  = cur_q;
  assign tail_o = tail_q;
  assign irq_o  = irq_calc(pend_q, ctrl_q[B_PEND +: NPEND]);

  p_tpm_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ctrl_q[B_TPM]);
  p_srst_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wr_ctrl) |=> !ctrl_q[B_SRST]);
  p_run_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wdata[B_RUN] && !wdata[B_SRST] && !ctrl_q[B_SRST] && !halt_set && !idle_set)
      |=> (!halted_q && !idle_q));
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[B_PEND] && !pend_evt[0]) |=> !pend_q[0]);
  p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend_evt[0] |=> pend_q[0]);
  p_halt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halt_set |=> halted_q);
  p_idle_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle_set |=> idle_q);
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(pend_evt & ctrl_q[B_PEND +: NPEND])) && !wr_ctrl) |=> irq_o);
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dmarb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NCH    = 2,
  parameter int WIN    = 48,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NCH-1:0]       eng_halt,
  input  logic [NCH-1:0]       eng_idle,
  input  logic [NCH*NPEND-1:0] eng_pend,
  input  logic [NCH*FLD_W-1:0] cnt_live,
  input  logic [NCH*FLD_W-1:0] tmr_live,
  output logic [NCH-1:0]       ch_run,
  output logic [NCH-1:0]       ch_srst,
  output logic [NCH*NPEND-1:0] ch_ien,
  output logic [NCH-1:0]       ch_irq,
  output logic                 tx_kick
);
  logic [CH_W-1:0] dec_chan;
  reg_sel_e        dec_sel;

  dmarb_decode #(.ADDR_W(ADDR_W), .NCH(NCH), .WIN(WIN)) u_dec (
    .addr(bus_addr), .chan(dec_chan), .sel(dec_sel)
  );

  logic          is_wr, is_rd;
  logic [DW-1:0] ctrl_v [NCH];
  logic [DW-1:0] stat_v [NCH];
  logic [DW-1:0] cur_v  [NCH];
  logic [DW-1:0] tail_v [NCH];

  assign is_wr = bus_valid && bus_write;
  assign is_rd = bus_valid && !bus_write;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = (dec_chan == CH_W'(g));
    dmarb_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (is_wr && hit && dec_sel == RG_CTRL),
      .wr_stat  (is_wr && hit && dec_sel == RG_STAT),
      .wr_cur   (is_wr && hit && dec_sel == RG_CUR),
      .wr_tail  (is_wr && hit && dec_sel == RG_TAIL),
      .rd_ctrl  (is_rd && hit && dec_sel == RG_CTRL),
      .wdata    (bus_wdata),
      .halt_set (eng_halt[g]),
      .idle_set (eng_idle[g]),
      .pend_evt (eng_pend[g*NPEND +: NPEND]),
      .cnt_live (cnt_live[g*FLD_W +: FLD_W]),
      .tmr_live (tmr_live[g*FLD_W +: FLD_W]),
      .ctrl_o   (ctrl_v[g]),
      .stat_o   (stat_v[g]),
      .cur_o    (cur_v[g]),
      .tail_o   (tail_v[g]),
      .irq_o    (ch_irq[g])
    );
    assign ch_run[g]                = ctrl_v[g][B_RUN];
    assign ch_srst[g]               = ctrl_v[g][B_SRST];
    assign ch_ien[g*NPEND +: NPEND] = ctrl_v[g][B_PEND +: NPEND];
  end

  logic [DW-1:0] rd_mux;
  always_comb begin
    case (dec_sel)
      RG_CTRL: rd_mux = ctrl_v[dec_chan] & ~(32'd1 << B_SRST);
      RG_STAT: rd_mux = stat_v[dec_chan];
      RG_CUR:  rd_mux = cur_v[dec_chan];
      RG_TAIL: rd_mux = tail_v[dec_chan];
      default: rd_mux = '0;
    endcase
  end

  logic kick_req;
  assign kick_req = is_wr && dec_sel == RG_TAIL && dec_chan == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      tx_kick   <= 1'b0;
    end else begin
      if (is_rd) bus_rdata <= rd_mux;
      tx_kick <= kick_req;
    end
  end

  p_kick_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |-> $past(kick_req));
  p_rdata_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> $stable(bus_rdata));
endmodule

// File: tb/dma_regbank_tb_top.sv
`timescale 1ns/1ps
module dma_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0]  eng_halt, eng_idle;
  logic [5:0]  eng_pend;
  logic [15:0] cnt_live, tmr_live;
  logic [1:0]  ch_run, ch_srst, ch_irq;
  logic [5:0]  ch_ien;
  logic        tx_kick;

  always #2.5 clk = ~clk;

  dma_regbank dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [2];
  logic [31:0] m_cur  [2];
  logic [31:0] m_tail [2];
  logic        m_halt [2];
  logic        m_idle [2];
  logic [2:0]  m_pend [2];

  function automatic logic [31:0] exp_stat(int c);
    return {tmr_live[c*8 +: 8], cnt_live[c*8 +: 8], 1'b0, m_pend[c], 10'd0, m_idle[c], m_halt[c]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(string tag, bit v, bit w, logic [7:0] a, logic [31:0] d,
                      logic [1:0] hs, logic [1:0] is, logic [5:0] ev);
    int ch, off;
    logic [31:0] exp_rd, nv;
    ch  = (int'(a) / 48) % 2;
    off = int'(a) % 48;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    eng_halt = hs; eng_idle = is; eng_pend = ev;
    @(posedge clk);
    case (off)
      0:  exp_rd = m_ctrl[ch] & ~32'h4;
      4:  exp_rd = exp_stat(ch);
      8:  exp_rd = m_cur[ch];
      16: exp_rd = m_tail[ch];
      default: exp_rd = 32'h0;
    endcase
    for (int c = 0; c < 2; c++) begin
      if (v && w && ch == c) begin
        if (off == 0) begin
          nv = d | 32'h2 | (m_ctrl[c] & 32'h4);
          if (nv[2]) begin
            m_ctrl[c] = 32'h0001_0006; m_halt[c] = 1; m_idle[c] = 0; m_pend[c] = 0;
          end else begin
            m_ctrl[c] = nv;
            if (nv[0]) begin m_halt[c] = 0; m_idle[c] = 0; end
          end
        end else if (off == 4) m_pend[c] = m_pend[c] & ~d[14:12];
        else if (off == 8) m_cur[c] = d;
        else if (off == 16) begin m_tail[c] = d; m_idle[c] = 0; end
      end
      if (v && !w && ch == c && off == 0) m_ctrl[c][2] = 1'b0;
      m_pend[c] = m_pend[c] | ev[c*3 +: 3];
      if (hs[c]) m_halt[c] = 1;
      if (is[c]) m_idle[c] = 1;
    end
    @(negedge clk);
    bus_valid = 0; eng_halt = 0; eng_idle = 0; eng_pend = 0;
    if (v && !w) chk({tag, " R1/R7 rdata"}, bus_rdata, exp_rd);
    chk({tag, " R8 kick"}, 32'(tx_kick), 32'(v && w && off == 16 && ch == 0));
    for (int c = 0; c < 2; c++) begin
      chk({tag, " R9 irq"}, 32'(ch_irq[c]), 32'(|(m_pend[c] & m_ctrl[c][14:12])));
      chk({tag, " R11 run"}, 32'(ch_run[c]), 32'(m_ctrl[c][0]));
      chk({tag, " R11 ien"}, 32'(ch_ien[c*3 +: 3]), 32'(m_ctrl[c][14:12]));
      chk({tag, " R3 srst"}, 32'(ch_srst[c]), 32'(m_ctrl[c][2]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    eng_halt = 0; eng_idle = 0; eng_pend = 0;
    cnt_live = 16'h5AA5; tmr_live = 16'hC33C;
    for (int c = 0; c < 2; c++) begin
      m_ctrl[c] = 32'h0001_0000; m_cur[c] = 0; m_tail[c] = 0;
      m_halt[c] = 1; m_idle[c] = 0; m_pend[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R4 reset values
    step("R4 ctrl", 1, 0, 8'h00, 0, 0, 0, 0);
    chk("R4 ctrl value", bus_rdata, 32'h0001_0000);
    step("R4 stat", 1, 0, 8'h34, 0, 0, 0, 0);
    chk("R4 stat value", bus_rdata, 32'hC35A_0001);
    step("R4 tail", 1, 0, 8'h40, 0, 0, 0, 0);
    // R2 forced mode bit
    step("R2 wr", 1, 1, 8'h30, 32'h0, 0, 0, 0);
    step("R2 rd", 1, 0, 8'h30, 0, 0, 0, 0);
    chk("R2 tpm", bus_rdata, 32'h0000_0002);
    // R5 run clears halted
    step("R5 run", 1, 1, 8'h00, 32'h0000_1001, 0, 0, 0);
    step("R5 stat", 1, 0, 8'h04, 0, 0, 0, 0);
    chk("R5 halted", bus_rdata[1:0], 32'h0);
    // R6 / R9 event and W1C collision
    step("R9 evt", 0, 0, 0, 0, 0, 0, 6'b000_001);
    chk("R9 irq high", 32'(ch_irq[0]), 32'h1);
    step("R6 collide", 1, 1, 8'h04, 32'h0000_1000, 0, 0, 6'b000_001);
    step("R6 rd", 1, 0, 8'h04, 0, 0, 0, 0);
    chk("R6 event wins", 32'(bus_rdata[12]), 32'h1);
    step("R6 w1c", 1, 1, 8'h04, 32'h0000_1000, 0, 0, 0);
    chk("R6 cleared irq", 32'(ch_irq[0]), 32'h0);
    // R8 kicks and R10 idle priority
    step("R8 tail0", 1, 1, 8'h10, 32'h1234_0040, 0, 0, 0);
    step("R8 tail1", 1, 1, 8'h40, 32'h0000_0080, 0, 0, 0);
    step("R10 idle", 1, 1, 8'h10, 32'h0000_0100, 0, 2'b01, 0);
    step("R10 rd", 1, 0, 8'h04, 0, 0, 0, 0);
    chk("R10 idle wins", 32'(bus_rdata[1]), 32'h1);
    step("R10 halt", 1, 1, 8'h00, 32'h1, 2'b01, 0, 0);
    // R3 soft reset on channel 1
    step("R3 pend", 0, 0, 0, 0, 0, 0, 6'b010_000);
    step("R3 srst", 1, 1, 8'h30, 32'h0000_1005, 0, 0, 0);
    chk("R3 srst out", 32'(ch_srst[1]), 32'h1);
    step("R3 run blocked", 1, 1, 8'h30, 32'h1, 0, 0, 0);
    step("R3 stat", 1, 0, 8'h34, 0, 0, 0, 0);
    chk("R3 halted only", bus_rdata[15:0], 32'h1);
    step("R3 ctrl rd", 1, 0, 8'h30, 0, 0, 0, 0);
    chk("R3 ctrl value", bus_rdata, 32'h0001_0002);
    step("R3 run ok", 1, 1, 8'h30, 32'h1, 0, 0, 0);
    // R1 unmapped and wrap
    step("R1 unmapped wr", 1, 1, 8'h0C, 32'hFFFF_FFFF, 0, 0, 0);
    step("R1 unmapped rd", 1, 0, 8'h0C, 0, 0, 0, 0);
    chk("R1 zero", bus_rdata, 32'h0);
    step("R1 cur wr", 1, 1, 8'h68, 32'hDEAD_BEE0, 0, 0, 0);
    step("R1 cur rd", 1, 0, 8'h08, 0, 0, 0, 0);
    chk("R1 wrap", bus_rdata, 32'hDEAD_BEE0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int offs_tab [7] = '{0, 4, 8, 12, 16, 20, 44};
      logic [31:0] d;
      logic [7:0]  a;
      cnt_live = 16'($urandom); tmr_live = 16'($urandom);
      a = 8'(($urandom % 5) * 48 + offs_tab[$urandom % 7]);
      d = $urandom;
      if ($urandom % 8 != 0) d[2] = 1'b0;
      step("RND", ($urandom % 4) != 0, $urandom % 2, a, d,
           ($urandom % 6 == 0) ? 2'($urandom) : 2'b0,
           ($urandom % 6 == 0) ? 2'($urandom) : 2'b0,
           ($urandom % 5 == 0) ? 6'($urandom) : 6'b0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule